// File: doc/BRIEF.md
# Single-Cycle Five-Instruction Processor Core

This block is a 32-bit processor core that retires one instruction on every clock edge. It runs a small subset: register-register arithmetic and logic (add, subtract, and, or, signed set-less-than), or with a zero-extended immediate, word load, word store and branch on equal. Inside are the program counter with its next-address logic, a 32-entry register bank, an immediate extender, an ALU, and control split over two levels. A main decoder turns the opcode into datapath selects and a 3-bit ALU class. A local decoder combines that class with the function field to pick the ALU operation.

Instruction and data storage are word arrays inside the core. A debug port writes either array and reads either array back combinationally. The usual flow is to hold the core in reset, load the program and data through the debug port, then release reset. Each cycle the core shows its commit on trace outputs: the current PC, the register write (enable, index, value) and the data store (enable, byte address, value). A register write or store shown in a cycle takes effect at the clock edge that ends that cycle.

Top module: `sc5_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC becomes 0. No register write or store is shown while `rst` is high. After release, the first instruction executed is at address 0.
- R2: Any instruction other than a taken branch moves the PC to PC+4 at the next edge.
- R3: With opcode 000000, the function bits [3:0] select the operation written to rd (bits [15:11]): 0000 rs+rt, 0010 rs-rt, 0100 rs AND rt, 0101 rs OR rt, 1010 set-less-than. Set-less-than writes 1 when rs < rt as signed values and 0 otherwise. rs is bits [25:21] and rt is bits [20:16].
- R4: Opcode 001101 writes rs OR the zero-extended immediate (bits [15:0]) to rt.
- R5: Opcode 100011 writes to rt the data word at byte address rs + sign-extended immediate. The word index is taken from address bits [DAW+1:2].
- R6: Opcode 101011 stores rt to the data word at byte address rs + sign-extended immediate, and writes no register. The stored word can be read back through the debug port.
- R7: Opcode 000100 writes nothing. When rs equals rt, the next PC is PC+4 + (sign-extended immediate << 2). Otherwise the next PC is PC+4.
- R8: Register 0 always reads as zero. An instruction whose destination is register 0 produces no register write.
- R9: Any other opcode writes no register and no memory, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_we | input | 1 | Debug write strobe |
| dbg_dmem | input | 1 | Debug target: 1 selects data array, 0 selects instruction array |
| dbg_addr | input | DBG_AW | Debug word index |
| dbg_wdata | input | XLEN | Debug write data |
| dbg_rdata | output | XLEN | Combinational debug read of the selected array |
| pc_o | output | XLEN | PC of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write at the end of this cycle |
| rf_waddr_o | output | 5 | Destination register index |
| rf_wdata_o | output | XLEN | Value written to the register |
| dm_we_o | output | 1 | Data store at the end of this cycle |
| dm_addr_o | output | XLEN | Byte address of the store or load |
| dm_wdata_o | output | XLEN | Value stored |

## Verification
The bench builds the core with its default 64-word instruction and data arrays. At that size, a negative store offset added to a large base wraps to a high word index such as 59, so that index sign extension, word-index truncation and readback over the debug port are all exercised. The program includes set-less-than with a negative operand, a write to register 0, an unknown opcode, a branch that is not taken, a forward taken branch that skips two instructions, and a backward branch to itself. With these, every ALU code and both next-PC paths are checked against a scoreboard fed by an instruction-level model.

// File: rtl/sc5_pkg.sv
package sc5_pkg;
   localparam logic [5:0] OP_RTYPE = 6'b000000;
   localparam logic [5:0] OP_ORI   = 6'b001101;
   localparam logic [5:0] OP_LW    = 6'b100011;
   localparam logic [5:0] OP_SW    = 6'b101011;
   localparam logic [5:0] OP_BEQ   = 6'b000100;

   localparam logic [2:0] CLS_ADD  = 3'b000;
   localparam logic [2:0] CLS_SUB  = 3'b001;
   localparam logic [2:0] CLS_OR   = 3'b010;
   localparam logic [2:0] CLS_FUNC = 3'b100;

   localparam logic [2:0] AOP_AND = 3'b000;
   localparam logic [2:0] AOP_OR  = 3'b001;
   localparam logic [2:0] AOP_ADD = 3'b010;
   localparam logic [2:0] AOP_SUB = 3'b110;
   localparam logic [2:0] AOP_SLT = 3'b111;

   typedef struct packed {
      logic       dst_rd;
      logic       src_imm;
      logic       wb_mem;
      logic       reg_wr;
      logic       mem_wr;
      logic       branch;
      logic       ext_sign;
      logic [2:0] alu_cls;
   } ctl_t;
endpackage

// File: rtl/sc5_ctrl.sv
module sc5_ctrl
   import sc5_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [3:0] func,
   output ctl_t       ctl,
   output logic [2:0] alu_op
);
   always_comb begin
      ctl = '0;
      unique case (opcode)
         OP_RTYPE: begin
            ctl.dst_rd  = 1'b1;
            ctl.reg_wr  = 1'b1;
            ctl.alu_cls = CLS_FUNC;
         end
         OP_ORI: begin
            ctl.src_imm = 1'b1;
            ctl.reg_wr  = 1'b1;
            ctl.alu_cls = CLS_OR;
         end
         OP_LW: begin
            ctl.src_imm  = 1'b1;
            ctl.ext_sign = 1'b1;
            ctl.wb_mem   = 1'b1;
            ctl.reg_wr   = 1'b1;
            ctl.alu_cls  = CLS_ADD;
         end
         OP_SW: begin
            ctl.src_imm  = 1'b1;
            ctl.ext_sign = 1'b1;
            ctl.mem_wr   = 1'b1;
            ctl.alu_cls  = CLS_ADD;
         end
         OP_BEQ: begin
            ctl.branch  = 1'b1;
            ctl.alu_cls = CLS_SUB;
         end
         default: ctl = '0;
      endcase
   end

   // local decoder: one sum of products per result bit
   logic c2, c1, c0;
   always_comb begin
      c2 = (!ctl.alu_cls[2] && ctl.alu_cls[0])
         || (ctl.alu_cls[2] && !func[2] && func[1] && !func[0]);
      c1 = (!ctl.alu_cls[2] && !ctl.alu_cls[1])
         || (ctl.alu_cls[2] && !func[2] && !func[0]);
      c0 = (!ctl.alu_cls[2] && ctl.alu_cls[1])
         || (ctl.alu_cls[2] && ((!func[3] && func[2] && !func[1] && func[0])
                             || (func[3] && !func[2] && func[1] && !func[0])));
      alu_op = {c2, c1, c0};
   end
endmodule

// File: rtl/sc5_regs.sv
module sc5_regs #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int RAW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            we,
   input  logic [RAW-1:0]  waddr,
   input  logic [XLEN-1:0] wdata,
   input  logic [RAW-1:0]  raddr_a,
   input  logic [RAW-1:0]  raddr_b,
   output logic [XLEN-1:0] rdata_a,
   output logic [XLEN-1:0] rdata_b
);
   logic [XLEN-1:0] rows [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_row
      if (i == 0) begin : g_zero
         assign rows[i] = '0;
      end else begin : g_live
         logic [XLEN-1:0] q;
         always_ff @(posedge clk) begin
            if (we && (waddr == RAW'(i))) q <= wdata;
         end
         assign rows[i] = q;
      end
   end

   assign rdata_a = rows[raddr_a];
   assign rdata_b = rows[raddr_b];
endmodule

// File: rtl/sc5_alu.sv
module sc5_alu
   import sc5_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [2:0]      op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] y,
   output logic            zero
);
   always_comb begin
      unique case (op)
         AOP_AND: y = a & b;
         AOP_OR:  y = a | b;
         AOP_ADD: y = a + b;
         AOP_SUB: y = a - b;
         AOP_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
         default: y = '0;
      endcase
      zero = (y == '0);
   end
endmodule

// File: rtl/sc5_pcgen.sv
module sc5_pcgen #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            take,
   input  logic [15:0]     offset,
   output logic [XLEN-1:0] pc
);
   logic [XLEN-1:0] seq_pc, tgt_pc;

   assign seq_pc = pc + XLEN'(4);
   assign tgt_pc = seq_pc + {{(XLEN-18){offset[15]}}, offset, 2'b00};

   always_ff @(posedge clk) begin
      if (rst) pc <= '0;
      else     pc <= take ? tgt_pc : seq_pc;
   end
endmodule

// File: rtl/sc5_core.sv
module sc5_core
   import sc5_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int IMEM_WORDS = 64,
   parameter int DMEM_WORDS = 64,
   localparam int IAW    = $clog2(IMEM_WORDS),
   localparam int DAW    = $clog2(DMEM_WORDS),
   localparam int DBG_AW = (IAW > DAW) ? IAW : DAW
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dbg_we,
   input  logic              dbg_dmem,
   input  logic [DBG_AW-1:0] dbg_addr,
   input  logic [XLEN-1:0]   dbg_wdata,
   output logic [XLEN-1:0]   dbg_rdata,
   output logic [XLEN-1:0]   pc_o,
   output logic              rf_we_o,
   output logic [4:0]        rf_waddr_o,
   output logic [XLEN-1:0]   rf_wdata_o,
   output logic              dm_we_o,
   output logic [XLEN-1:0]   dm_addr_o,
   output logic [XLEN-1:0]   dm_wdata_o
);
   if (XLEN != 32) begin : g_bad_xlen
      $error("sc5_core: XLEN must be 32 for this instruction format");
   end
   if (IMEM_WORDS < 2 || (1 << IAW) != IMEM_WORDS) begin : g_bad_imem
      $error("sc5_core: IMEM_WORDS must be a power of two >= 2");
   end
   if (DMEM_WORDS < 2 || (1 << DAW) != DMEM_WORDS) begin : g_bad_dmem
      $error("sc5_core: DMEM_WORDS must be a power of two >= 2");
   end

   logic [XLEN-1:0] imem [IMEM_WORDS];
   logic [XLEN-1:0] dmem [DMEM_WORDS];

   logic [XLEN-1:0] pc, instr, ra_dat, rb_dat, ext_imm, alu_b, alu_y, wb_val, ld_val;
   logic [4:0]      wr_idx;
   logic [2:0]      alu_op;
   logic            alu_zero, br_take, rf_we, dm_we;
   ctl_t            ctl;
   logic            unused_shamt;

   assign instr        = imem[pc[IAW+1:2]];
   assign unused_shamt = ^instr[10:6];

   sc5_ctrl u_ctrl (
      .opcode (instr[31:26]),
      .func   (instr[3:0]),
      .ctl    (ctl),
      .alu_op (alu_op)
   );

   sc5_regs #(.XLEN(XLEN), .NREG(32)) u_regs (
      .clk     (clk),
      .we      (rf_we),
      .waddr   (wr_idx),
      .wdata   (wb_val),
      .raddr_a (instr[25:21]),
      .raddr_b (instr[20:16]),
      .rdata_a (ra_dat),
      .rdata_b (rb_dat)
   );

   assign ext_imm = ctl.ext_sign ? {{(XLEN-16){instr[15]}}, instr[15:0]}
                                 : {{(XLEN-16){1'b0}}, instr[15:0]};
   assign alu_b   = ctl.src_imm ? ext_imm : rb_dat;

   sc5_alu #(.XLEN(XLEN)) u_alu (
      .op   (alu_op),
      .a    (ra_dat),
      .b    (alu_b),
      .y    (alu_y),
      .zero (alu_zero)
   );

   assign br_take = ctl.branch && alu_zero && !rst;

   sc5_pcgen #(.XLEN(XLEN)) u_pc (
      .clk    (clk),
      .rst    (rst),
      .take   (br_take),
      .offset (instr[15:0]),
      .pc     (pc)
   );

   assign ld_val = dmem[alu_y[DAW+1:2]];
   assign wr_idx = ctl.dst_rd ? instr[15:11] : instr[20:16];
   assign wb_val = ctl.wb_mem ? ld_val : alu_y;
   assign rf_we  = ctl.reg_wr && !rst && (wr_idx != 5'd0);
   assign dm_we  = ctl.mem_wr && !rst;

   always_ff @(posedge clk) begin
      if (dbg_we && !dbg_dmem) imem[dbg_addr[IAW-1:0]] <= dbg_wdata;
   end

   always_ff @(posedge clk) begin
      if (dbg_we && dbg_dmem) dmem[dbg_addr[DAW-1:0]] <= dbg_wdata;
      else if (dm_we)         dmem[alu_y[DAW+1:2]]   <= rb_dat;
   end

   assign dbg_rdata  = dbg_dmem ? dmem[dbg_addr[DAW-1:0]] : imem[dbg_addr[IAW-1:0]];
   assign pc_o       = pc;
   assign rf_we_o    = rf_we;
   assign rf_waddr_o = wr_idx;
   assign rf_wdata_o = wb_val;
   assign dm_we_o    = dm_we;
   assign dm_addr_o  = alu_y;
   assign dm_wdata_o = rb_dat;
endmodule

// File: rtl/sc5_core_chk.sv
module sc5_core_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst,
   input logic [XLEN-1:0] pc,
   input logic [XLEN-1:0] instr,
   input logic            take,
   input logic            rf_we,
   input logic [4:0]      rf_waddr,
   input logic            dm_we,
   input logic [XLEN-1:0] ra_dat
);
   logic known_op;
   assign known_op = instr[31:26] inside {6'b000000, 6'b001101, 6'b100011, 6'b101011, 6'b000100};

   AST_PC_RESET: assert property (@(posedge clk) rst |=> (pc == '0)); // R1
   AST_QUIET_IN_RESET: assert property (@(posedge clk) rst |-> (!rf_we && !dm_we)); // R1
   AST_PC_SEQ: assert property (@(posedge clk) disable iff (rst) !take |=> (pc == $past(pc) + XLEN'(4))); // R2
   AST_BR_TARGET: assert property (@(posedge clk) disable iff (rst)
      take |=> (pc == $past(pc) + XLEN'(4) + {{(XLEN-18){$past(instr[15])}}, $past(instr[15:0]), 2'b00})); // R7
   AST_ONE_SINK: assert property (@(posedge clk) disable iff (rst) !(rf_we && dm_we)); // R6
   AST_R0_READ: assert property (@(posedge clk) disable iff (rst) (instr[25:21] == 5'd0) |-> (ra_dat == '0)); // R8
   AST_R0_NOWRITE: assert property (@(posedge clk) disable iff (rst) rf_we |-> (rf_waddr != 5'd0)); // R8
   AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (rst) !known_op |-> (!rf_we && !dm_we && !take)); // R9
endmodule

bind sc5_core sc5_core_chk #(.XLEN(XLEN)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .pc       (pc),
   .instr    (instr),
   .take     (br_take),
   .rf_we    (rf_we),
   .rf_waddr (wr_idx),
   .dm_we    (dm_we),
   .ra_dat   (ra_dat)
);

// File: tb/tb_sc5_core.sv
`timescale 1ns/1ps
module tb_sc5_core;
   localparam int XLEN = 32;
   localparam int NW   = 64;
   localparam int AW   = 6;
   localparam int NSTEP = 40;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic dbg_we = 1'b0, dbg_dmem = 1'b0;
   logic [AW-1:0] dbg_addr = '0;
   logic [XLEN-1:0] dbg_wdata = '0, dbg_rdata, pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
   logic rf_we_o, dm_we_o;
   logic [4:0] rf_waddr_o;

   always #5 clk = ~clk;

   sc5_core #(.XLEN(XLEN), .IMEM_WORDS(NW), .DMEM_WORDS(NW)) dut (
      .clk(clk), .rst(rst), .dbg_we(dbg_we), .dbg_dmem(dbg_dmem), .dbg_addr(dbg_addr),
      .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .pc_o(pc_o), .rf_we_o(rf_we_o),
      .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o),
      .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o));

   typedef struct {
      logic [31:0] pc;
      logic        rwe;
      logic [4:0]  rwa;
      logic [31:0] rwd;
      logic        dwe;
      logic [31:0] dad;
      logic [31:0] dwd;
      string       tag;
   } exp_t;

   exp_t        sb [$];
   event        item_ev;
   int          n_chk = 0, n_fail = 0;
   logic [31:0] prog [NW];
   logic [31:0] mrf  [32];
   logic [31:0] mdm  [NW];
   logic [31:0] mpc;

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
      return {6'b0, 5'(rs), 5'(rt), 5'(rd), 5'b0, fn};
   endfunction
   function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic dbg_write(bit to_d, int idx, logic [31:0] v);
      @(negedge clk);
      dbg_we = 1'b1; dbg_dmem = to_d; dbg_addr = AW'(idx); dbg_wdata = v;
      @(negedge clk);
      dbg_we = 1'b0;
   endtask

   // driver: instruction-level model of R2..R9 pushes one expected commit
   task automatic push_expect();
      exp_t e;
      logic [31:0] ins, a, b, sx, v, nxt;
      logic [5:0] op;
      ins = prog[mpc[7:2]];
      op  = ins[31:26];
      a   = (ins[25:21] == 0) ? 32'd0 : mrf[ins[25:21]];
      b   = (ins[20:16] == 0) ? 32'd0 : mrf[ins[20:16]];
      sx  = {{16{ins[15]}}, ins[15:0]};
      e.pc = mpc; e.rwe = 0; e.rwa = 0; e.rwd = 0; e.dwe = 0; e.dad = 0; e.dwd = 0;
      nxt = mpc + 4; v = 0;
      e.tag = "R9";
      case (op)
         6'b000000: begin
            case (ins[3:0])
               4'b0000: v = a + b;
               4'b0010: v = a - b;
               4'b0100: v = a & b;
               4'b0101: v = a | b;
               4'b1010: v = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
               default: v = 0;
            endcase
            e.rwa = ins[15:11]; e.rwe = (ins[15:11] != 0);
            e.tag = e.rwe ? "R3 R2" : "R8 R2";
         end
         6'b001101: begin
            v = a | {16'h0, ins[15:0]};
            e.rwa = ins[20:16]; e.rwe = (ins[20:16] != 0); e.tag = "R4 R2";
         end
         6'b100011: begin
            e.dad = a + sx; v = mdm[e.dad[7:2]];
            e.rwa = ins[20:16]; e.rwe = (ins[20:16] != 0); e.tag = "R5 R2";
         end
         6'b101011: begin
            e.dwe = 1; e.dad = a + sx; e.dwd = b;
            mdm[e.dad[7:2]] = b; e.tag = "R6 R2";
         end
         6'b000100: begin
            if (a == b) nxt = mpc + 4 + {sx[29:0], 2'b00};
            e.tag = "R7";
         end
         default: e.tag = "R9 R2";
      endcase
      e.rwd = v;
      if (e.rwe) mrf[e.rwa] = v;
      mpc = nxt;
      sb.push_back(e);
   endtask

   // monitor: pops an expected commit and compares mid-cycle
   initial begin
      forever begin
         exp_t e;
         @(item_ev);
         #1;
         e = sb.pop_front();
         check(pc_o == e.pc, {e.tag, " pc"}, pc_o, e.pc);
         check((rf_we_o == e.rwe) && (!e.rwe || (rf_waddr_o == e.rwa && rf_wdata_o == e.rwd)),
               {e.tag, " regwrite"}, {rf_we_o, 26'd0, rf_waddr_o} ^ rf_wdata_o, {e.rwe, 26'd0, e.rwa} ^ e.rwd);
         check((dm_we_o == e.dwe) && (!e.dwe || (dm_addr_o == e.dad && dm_wdata_o == e.dwd)),
               {e.tag, " store"}, e.dwe ? dm_wdata_o : 32'(dm_we_o), e.dwe ? e.dwd : 32'(e.dwe));
      end
   end

   task automatic run_all();
      for (int i = 0; i < NW; i++) prog[i] = 32'hFC00_0000;
      prog[0]  = enc_i(6'b001101, 0, 1, 16'h0005);
      prog[1]  = enc_i(6'b001101, 0, 2, 16'hFFF0);
      prog[2]  = enc_i(6'b100011, 0, 3, 16'h0008);
      prog[3]  = enc_r(1, 2, 4, 6'b100000);
      prog[4]  = enc_r(1, 3, 5, 6'b100010);
      prog[5]  = enc_r(2, 3, 6, 6'b100100);
      prog[6]  = enc_r(1, 3, 7, 6'b100101);
      prog[7]  = enc_r(3, 1, 8, 6'b101010);
      prog[8]  = enc_r(1, 3, 9, 6'b101010);
      prog[9]  = enc_i(6'b101011, 0, 4, 16'h000C);
      prog[10] = enc_i(6'b101011, 6, 5, 16'hFFFC);
      prog[11] = enc_r(1, 1, 0, 6'b100000);
      prog[12] = enc_r(0, 1, 10, 6'b100000);
      prog[13] = 32'hFC22_0001;
      prog[14] = enc_i(6'b000100, 1, 9, 16'h0002);
      prog[15] = enc_i(6'b000100, 10, 1, 16'h0002);
      prog[16] = enc_i(6'b001101, 0, 11, 16'h0BAD);
      prog[17] = enc_i(6'b001101, 0, 11, 16'h0BAD);
      prog[18] = enc_i(6'b100011, 0, 12, 16'h000C);
      prog[19] = enc_i(6'b000100, 0, 0, 16'hFFFF);
      for (int i = 0; i < NW; i++) mdm[i] = 32'h0101_0101 * i;
      mdm[2] = 32'hFFFF_FFF9;
      for (int i = 0; i < 32; i++) mrf[i] = 32'd0;
      mpc = 0;
      rst = 1'b1;
      for (int i = 0; i < NW; i++) dbg_write(1'b0, i, prog[i]);
      for (int i = 0; i < NW; i++) dbg_write(1'b1, i, mdm[i]);
      @(negedge clk);
      // R1: in reset, PC is 0 and nothing is written
      check(pc_o == 0 && !rf_we_o && !dm_we_o, "R1 reset", {pc_o[30:0], rf_we_o | dm_we_o}, 32'd0);
      rst = 1'b0;
      for (int s = 0; s < NSTEP; s++) begin
         push_expect();
         -> item_ev;
         @(negedge clk);
      end
      rst = 1'b1;
      @(negedge clk);
      dbg_dmem = 1'b1;
      foreach (mdm[i]) if (i == 2 || i == 3 || i == 59) begin
         dbg_addr = AW'(i);
         #1;
         // R6: stored words visible through the debug port
         check(dbg_rdata == mdm[i], "R6 readback", dbg_rdata, mdm[i]);
      end
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, NSTEP);
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule